// File: doc/BRIEF.md
# SPI Serial Memory Slave

This block is the slave side of a byte-addressed serial memory sitting on an SPI bus in mode 0. The bus pins (chip select, serial clock, serial data in, pause) are sampled by the fast system clock and converted into clock-edge strobes. A state machine then shifts in an 8-bit opcode, an optional 16-bit address and data bytes, all most significant bit first. It stores bytes in a small register array, returns them on the serial output, and keeps a write-enable latch, a status register, an erase sweeper and a deep power-down flag.

The serial output is presented as a data bit plus an enable, which together form a tri-state driver. The enable is active only while a byte is being shifted out to the master. The address field is always 16 bits wide. Bits above the array's own address width alias, so addresses wrap modulo `DEPTH`.

States are `ST_IDLE` (select high), `ST_OPCODE`, `ST_ADDR`, `ST_WR_IN`, `ST_STAT_IN`, `ST_DUMMY`, `ST_RD_OUT`, `ST_STAT_OUT`, `ST_SIG_OUT` and `ST_SKIP`. The transitions are as follows:
- Select going low moves `ST_IDLE` to `ST_OPCODE`.
- A completed opcode byte moves to `ST_ADDR` (read, write, page/sector erase), `ST_STAT_OUT` (status read), `ST_STAT_IN` (status write), `ST_DUMMY` (wake/signature) or `ST_SKIP` (everything else, and every refused command).
- The second address byte moves `ST_ADDR` to `ST_RD_OUT`, `ST_WR_IN` or `ST_SKIP` (erases).
- The status-write byte moves `ST_STAT_IN` to `ST_SKIP`.
- The third dummy byte moves `ST_DUMMY` to `ST_SIG_OUT`.
- Select going high returns any state to `ST_IDLE`. If a command is armed and the bit count sits on a byte boundary, the command is committed at that moment.

Top module: `spimem_slave`

## Requirements
- R1: After reset `so_oe` is 0, the status byte reads 0x00 and every array byte holds 0x00.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The status byte layout is: bit 1 is the latch, bit 0 is the erase-busy flag, and bits 7:2 are user bits.
- R3: Data in is sampled on rising serial-clock edges and data out changes on falling edges, MSB first. Opcode 0x02 followed by a 16-bit address stores each following byte at consecutive addresses. Opcode 0x03 followed by a 16-bit address returns bytes from consecutive addresses for as long as clocking continues. Addresses wrap modulo `DEPTH`.
- R4: Write (0x02), status write (0x01) and the erases (0x42, 0xD8, 0xC7) have no effect while the latch is clear.
- R5: An accepted write-class command clears the latch when select rises on a byte boundary. If select rises mid-byte, the latch stays set.
- R6: Opcode 0x05 returns the status byte repeatedly while clocking continues.
- R7: Opcode 0x01 with one data byte loads status bits 7:2 from that byte's bits 7:2. Bits 1:0 are not writable.
- R8: Page erase (0x42 + address) fills the `PAGE`-aligned page containing the address with 0xFF. Sector erase (0xD8 + address) does the same for the `SECTOR`-aligned block. Chip erase (0xC7) fills the whole array. Busy is 1 while the sweep runs, and every opcode except 0x05 is refused while busy.
- R9: An unknown opcode leaves all state unchanged and keeps `so_oe` low until select goes high.
- R10: After opcode 0xB9 and select rising, every opcode except 0xAB is refused. Opcode 0xAB clears power-down, takes three dummy bytes and then repeats the signature byte `SIG`.
- R11: While `hold_n` is low, serial-clock edges are ignored and `so_oe` is 0. After release the transfer resumes at the same bit.
- R12: `so_oe` is 0 while select is high and during opcode and address phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are oversampled |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idles low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transfer pause |
| so_d | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out enable (tri-state control) |

## Verification
The hardest situation to reach is a command arriving while an erase sweep is still running. The bench slows the sweep with `STEP` clocks per byte, so a chip erase lasts thousands of cycles. It then issues a status read at once, which must show busy, followed by a write-enable, which must be refused. The refusal is confirmed by a later status read that finds the latch still clear. The HOLD pause is exercised in the middle of a read data byte, with serial-clock toggles injected during the pause that must not shift any bits.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_OPCODE, ST_ADDR, ST_WR_IN, ST_STAT_IN,
        ST_DUMMY, ST_RD_OUT, ST_STAT_OUT, ST_SIG_OUT, ST_SKIP
    } state_t;

    typedef enum logic [2:0] {
        K_NONE, K_READ, K_WRITE, K_WRSR, K_PAGE, K_SECTOR, K_CHIP, K_SLEEP
    } commit_t;

    localparam logic [7:0] OP_RD    = 8'h03;
    localparam logic [7:0] OP_WR    = 8'h02;
    localparam logic [7:0] OP_SETWE = 8'h06;
    localparam logic [7:0] OP_CLRWE = 8'h04;
    localparam logic [7:0] OP_GETSR = 8'h05;
    localparam logic [7:0] OP_PUTSR = 8'h01;
    localparam logic [7:0] OP_PGER  = 8'h42;
    localparam logic [7:0] OP_SCER  = 8'hD8;
    localparam logic [7:0] OP_CHER  = 8'hC7;
    localparam logic [7:0] OP_WAKE  = 8'hAB;
    localparam logic [7:0] OP_SLEEP = 8'hB9;
endpackage

// File: rtl/spimem_sampler.sv
module spimem_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    output logic cs_s,
    output logic si_s,
    output logic hold_s,
    output logic rise,
    output logic fall,
    output logic cs_rise
);
    logic sck_s, sck_p, cs_p, live;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_s   <= 1'b1;
            cs_p   <= 1'b1;
            sck_s  <= 1'b0;
            sck_p  <= 1'b0;
            si_s   <= 1'b0;
            hold_s <= 1'b1;
        end else begin
            cs_s   <= cs_n;
            cs_p   <= cs_s;
            sck_s  <= sck;
            sck_p  <= sck_s;
            si_s   <= si;
            hold_s <= hold_n;
        end
    end

    assign live    = !cs_s && hold_s;
    assign rise    = live && sck_s && !sck_p;
    assign fall    = live && !sck_s && sck_p;
    assign cs_rise = cs_s && !cs_p;
endmodule

// File: rtl/spimem_array.sv
module spimem_array #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spimem_eraser.sv
module spimem_eraser #(
    parameter int DEPTH = 256,
    parameter int STEP  = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base,
    input  logic [AW:0]   count,
    output logic          busy,
    output logic          we,
    output logic [AW-1:0] waddr
);
    localparam int TW = (STEP > 1) ? $clog2(STEP) : 1;

    logic [AW-1:0] ptr;
    logic [AW:0]   left;
    logic [TW-1:0] tick;
    logic          step_done;

    assign step_done = (tick == TW'(STEP - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ptr  <= '0;
            left <= '0;
            tick <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            ptr  <= base;
            left <= count;
            tick <= '0;
        end else if (busy) begin
            if (step_done) begin
                tick <= '0;
                ptr  <= ptr + AW'(1);
                left <= left - (AW+1)'(1);
                if (left == (AW+1)'(1)) busy <= 1'b0;
            end else begin
                tick <= tick + TW'(1);
            end
        end
    end

    assign we    = busy && step_done;
    assign waddr = ptr;

    // R8
    erase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R8
    erase_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (left != '0));
endmodule

// File: rtl/spimem_slave.sv
module spimem_slave
    import spimem_pkg::*;
#(
    parameter int         DEPTH  = 256,
    parameter int         PAGE   = 16,
    parameter int         SECTOR = 64,
    parameter int         STEP   = 16,
    parameter logic [7:0] SIG    = 8'h29
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    output logic so_d,
    output logic so_oe
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] PG_MASK = ~AW'(PAGE - 1);
    localparam logic [AW-1:0] SC_MASK = ~AW'(SECTOR - 1);

    logic cs_s, si_s, hold_s, rise, fall, cs_rise;
    state_t st;
    commit_t kind;
    logic [6:0]  in_sh;
    logic [2:0]  icnt, ocnt;
    logic [1:0]  acnt;
    logic [15:0] addr, addr_inc, new_addr;
    logic [7:0]  byte_in, out_byte, rd_data, wdata, status;
    logic [5:0]  sr_user, cap;
    logic        wel, dpd, armed, act, so_q, byte_done, commit;
    logic        wr_we, er_start, er_busy, er_we, mem_we, out_st;
    logic [AW-1:0] rd_addr, er_addr, waddr, er_base;
    logic [AW:0]   er_cnt;

    spimem_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .cs_s(cs_s), .si_s(si_s), .hold_s(hold_s), .rise(rise), .fall(fall),
        .cs_rise(cs_rise)
    );

    spimem_array #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(waddr), .wdata(wdata),
        .raddr(rd_addr), .rdata(rd_data)
    );

    spimem_eraser #(.DEPTH(DEPTH), .STEP(STEP), .AW(AW)) u_ers (
        .clk(clk), .rst_n(rst_n), .start(er_start), .base(er_base), .count(er_cnt),
        .busy(er_busy), .we(er_we), .waddr(er_addr)
    );

    assign byte_in   = {in_sh, si_s};
    assign byte_done = rise && (icnt == 3'd7);
    assign new_addr  = {addr[7:0], byte_in};
    assign addr_inc  = addr + 16'd1;
    assign status    = {sr_user, wel, er_busy};
    assign rd_addr   = (st == ST_ADDR) ? new_addr[AW-1:0] : addr_inc[AW-1:0];
    assign wr_we     = byte_done && (st == ST_WR_IN);
    assign mem_we    = wr_we || er_we;
    assign wdata     = er_we ? 8'hFF : byte_in;
    assign waddr     = er_we ? er_addr : addr[AW-1:0];
    assign commit    = cs_rise && armed && (icnt == 3'd0);
    assign out_st    = (st == ST_RD_OUT) || (st == ST_STAT_OUT) || (st == ST_SIG_OUT);

    always_comb begin
        er_start = 1'b0;
        er_base  = '0;
        er_cnt   = (AW+1)'(DEPTH);
        if (commit) begin
            unique case (kind)
                K_PAGE:   begin er_start = 1'b1; er_base = addr[AW-1:0] & PG_MASK; er_cnt = (AW+1)'(PAGE); end
                K_SECTOR: begin er_start = 1'b1; er_base = addr[AW-1:0] & SC_MASK; er_cnt = (AW+1)'(SECTOR); end
                K_CHIP:   er_start = 1'b1;
                default:  er_start = 1'b0;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;   kind <= K_NONE;  in_sh <= '0;  icnt <= '0;
            ocnt <= '0;      acnt <= '0;      addr <= '0;   out_byte <= '0;
            sr_user <= '0;   cap <= '0;       wel <= 1'b0;  dpd <= 1'b0;
            armed <= 1'b0;   act <= 1'b0;     so_q <= 1'b0;
        end else if (cs_s) begin
            if (commit) begin
                unique case (kind)
                    K_WRITE, K_PAGE, K_SECTOR, K_CHIP: wel <= 1'b0;
                    K_WRSR:  begin wel <= 1'b0; sr_user <= cap; end
                    K_SLEEP: dpd <= 1'b1;
                    default: ;
                endcase
            end
            st <= ST_IDLE; icnt <= '0; acnt <= '0; ocnt <= '0;
            armed <= 1'b0; act <= 1'b0;
        end else begin
            if (st == ST_IDLE) st <= ST_OPCODE;
            if (rise) begin
                in_sh <= {in_sh[5:0], si_s};
                icnt  <= icnt + 3'd1;
            end
            if (byte_done) begin
                unique case (st)
                    ST_IDLE, ST_OPCODE: begin
                        st <= ST_SKIP;
                        if (!((dpd && byte_in != OP_WAKE) || (er_busy && byte_in != OP_GETSR))) begin
                            case (byte_in)
                                OP_RD:    begin kind <= K_READ; st <= ST_ADDR; end
                                OP_WR:    if (wel) begin kind <= K_WRITE; st <= ST_ADDR; end
                                OP_SETWE: wel <= 1'b1;
                                OP_CLRWE: wel <= 1'b0;
                                OP_GETSR: begin st <= ST_STAT_OUT; out_byte <= status; ocnt <= '0; end
                                OP_PUTSR: if (wel) begin kind <= K_WRSR; st <= ST_STAT_IN; end
                                OP_PGER:  if (wel) begin kind <= K_PAGE; st <= ST_ADDR; end
                                OP_SCER:  if (wel) begin kind <= K_SECTOR; st <= ST_ADDR; end
                                OP_CHER:  if (wel) begin kind <= K_CHIP; armed <= 1'b1; end
                                OP_WAKE:  begin dpd <= 1'b0; st <= ST_DUMMY; end
                                OP_SLEEP: begin kind <= K_SLEEP; armed <= 1'b1; end
                                default:  ;
                            endcase
                        end
                    end
                    ST_ADDR: begin
                        addr <= new_addr;
                        acnt <= acnt + 2'd1;
                        if (acnt == 2'd1) begin
                            if (kind == K_READ) begin
                                st <= ST_RD_OUT; out_byte <= rd_data; ocnt <= '0;
                            end else if (kind == K_WRITE) begin
                                st <= ST_WR_IN;
                            end else begin
                                st <= ST_SKIP; armed <= 1'b1;
                            end
                        end
                    end
                    ST_WR_IN:   begin addr <= addr_inc; armed <= 1'b1; end
                    ST_STAT_IN: begin cap <= byte_in[7:2]; armed <= 1'b1; st <= ST_SKIP; end
                    ST_DUMMY: begin
                        acnt <= acnt + 2'd1;
                        if (acnt == 2'd2) begin st <= ST_SIG_OUT; out_byte <= SIG; ocnt <= '0; end
                    end
                    default: ;
                endcase
            end
            if (fall && out_st) begin
                so_q <= out_byte[3'd7 - ocnt];
                act  <= 1'b1;
                ocnt <= ocnt + 3'd1;
                if (ocnt == 3'd7) begin
                    unique case (st)
                        ST_RD_OUT:   begin addr <= addr_inc; out_byte <= rd_data; end
                        ST_STAT_OUT: out_byte <= status;
                        default:     out_byte <= SIG;
                    endcase
                end
            end
        end
    end

    // outputs
    always_comb begin
        so_d  = so_q;
        so_oe = act && out_st && hold_s && !cs_s;
    end

    // R4
    wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_we |-> wel);
    // R10
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> !dpd);
    // R11
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_s && !cs_s) |=> $stable(icnt));
    // R3
    so_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(so_q));
endmodule

// File: tb/tb_spimem_slave.sv
`timescale 1ns/1ps
module tb_spimem_slave;
    localparam int H = 4;
    localparam logic [7:0] SIGV = 8'h29;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so_d, so_oe;
    int nchk = 0, nerr = 0;
    logic oe_seen;
    logic [7:0] r, r2, r3;

    always #2.5 clk = ~clk;

    spimem_slave dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
                      .hold_n(hold_n), .so_d(so_d), .so_oe(so_oe));

    // {address, data}
    localparam logic [23:0] VEC [6] = '{
        {16'h0003, 8'hA5}, {16'h1234, 8'h3C}, {16'h00FF, 8'h81},
        {16'h7F10, 8'h5E}, {16'h0090, 8'hC3}, {16'h0031, 8'h96}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic xbit(input logic b, output logic rb);
        @(negedge clk); sck = 1'b0; si = b;
        repeat (H) @(negedge clk);
        rb = so_d;
        if (so_oe) oe_seen = 1'b1;
        sck = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) xbit(tx[i], rx[i]);
    endtask

    task automatic start();
        oe_seen = 1'b0; sck = 1'b0; cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic stop();
        @(negedge clk); sck = 1'b0;
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (2*H) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] d;
        start(); xbyte(op, d); stop();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        start(); xbyte(8'h05, d); xbyte(8'h00, s); stop();
    endtask

    task automatic wr1(input logic [15:0] a, input logic [7:0] v);
        logic [7:0] d;
        start(); xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d); xbyte(v, d); stop();
    endtask

    task automatic rd1(input logic [15:0] a, output logic [7:0] v);
        logic [7:0] d;
        start(); xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d); xbyte(8'h00, v); stop();
    endtask

    task automatic erase(input logic [7:0] op, input logic [15:0] a);
        logic [7:0] d;
        start(); xbyte(op, d); xbyte(a[15:8], d); xbyte(a[7:0], d); stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic b;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 so_oe", {7'd0, so_oe}, 8'h00);
        rdsr(r); chk("R1 status", r, 8'h00);
        rd1(16'h0040, r); chk("R1 array", r, 8'h00);

        // R3 vector walk: write then read back
        foreach (VEC[i]) begin
            cmd(8'h06);
            wr1(VEC[i][23:8], VEC[i][7:0]);
            rd1(VEC[i][23:8], r);
            chk("R3 vector", r, VEC[i][7:0]);
        end

        // R3 multi-byte write and sequential read; R12 input phases quiet
        cmd(8'h06);
        start(); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h20, d);
        xbyte(8'h11, d); xbyte(8'h22, d); xbyte(8'h33, d); stop();
        start(); xbyte(8'h03, d); xbyte(8'h00, d); xbyte(8'h20, d);
        chk("R12 oe during opcode/address", {7'd0, oe_seen}, 8'h00);
        xbyte(8'h00, r); xbyte(8'h00, r2); xbyte(8'h00, r3); stop();
        chk("R3 seq 0", r, 8'h11); chk("R3 seq 1", r2, 8'h22); chk("R3 seq 2", r3, 8'h33);
        chk("R12 oe with cs high", {7'd0, so_oe}, 8'h00);
        // R3 wrap at DEPTH
        start(); xbyte(8'h03, d); xbyte(8'h00, d); xbyte(8'hFF, d);
        xbyte(8'h00, r); xbyte(8'h00, r2); stop();
        chk("R3 wrap last", r, 8'h81); chk("R3 wrap first", r2, 8'h00);

        // R2 latch set/clear
        cmd(8'h06); rdsr(r); chk("R2 set", r, 8'h02);
        // R6 repeated status
        start(); xbyte(8'h05, d); xbyte(0, r); xbyte(0, r2); xbyte(0, r3); stop();
        chk("R6 rep0", r, 8'h02); chk("R6 rep1", r2, 8'h02); chk("R6 rep2", r3, 8'h02);
        cmd(8'h04); rdsr(r); chk("R2 clear", r, 8'h00);

        // R4 gating with latch clear
        wr1(16'h0031, 8'h77); rd1(16'h0031, r); chk("R4 write refused", r, 8'h96);
        erase(8'h42, 16'h0031); rdsr(r); chk("R4 erase refused busy", r, 8'h00);
        rd1(16'h0031, r); chk("R4 erase refused data", r, 8'h96);

        // R5 latch cleared on boundary, kept mid-byte
        cmd(8'h06); wr1(16'h0050, 8'h66); rdsr(r); chk("R5 cleared", r, 8'h00);
        cmd(8'h06);
        start(); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h51, d); xbyte(8'h44, d);
        xbit(1'b1, b); xbit(1'b0, b); xbit(1'b1, b); stop();
        rdsr(r); chk("R5 mid-byte kept", r, 8'h02);
        rd1(16'h0051, r); chk("R5 mid-byte data", r, 8'h44);
        cmd(8'h04);

        // R9 unknown opcode
        start(); xbyte(8'h77, d); xbyte(8'h00, d); stop();
        chk("R9 oe quiet", {7'd0, oe_seen}, 8'h00);
        rdsr(r); chk("R9 no side effect", r, 8'h00);

        // R11 hold mid data byte
        start(); xbyte(8'h03, d); xbyte(8'h00, d); xbyte(8'h20, d);
        xbit(1'b0, r[7]); xbit(1'b0, r[6]); xbit(1'b0, r[5]);
        hold_n = 1'b0; repeat (H) @(negedge clk);
        chk("R11 oe in hold", {7'd0, so_oe}, 8'h00);
        sck = 1'b0; repeat (H) @(negedge clk); sck = 1'b1; repeat (H) @(negedge clk);
        sck = 1'b0; repeat (H) @(negedge clk); sck = 1'b1; repeat (H) @(negedge clk);
        hold_n = 1'b1; repeat (H) @(negedge clk);
        for (int i = 4; i >= 0; i--) xbit(1'b0, r[i]);
        xbyte(8'h00, r2); stop();
        chk("R11 resumed byte", r, 8'h11); chk("R11 next byte", r2, 8'h22);

        // R8 page erase
        cmd(8'h06); erase(8'h42, 16'h0025);
        rdsr(r); chk("R8 page busy", r, 8'h01);
        repeat (400) @(negedge clk);
        rd1(16'h0021, r); chk("R8 page erased", r, 8'hFF);
        rd1(16'h0031, r); chk("R8 page neighbour", r, 8'h96);
        // R8 sector erase
        cmd(8'h06); erase(8'hD8, 16'h0085);
        repeat (1200) @(negedge clk);
        rd1(16'h0090, r); chk("R8 sector erased", r, 8'hFF);
        rd1(16'h0051, r); chk("R8 sector outside", r, 8'h44);
        // R8 chip erase, commands refused while busy
        cmd(8'h06); cmd(8'hC7);
        rdsr(r); chk("R8 chip busy", r, 8'h01);
        cmd(8'h06);
        repeat (4400) @(negedge clk);
        rdsr(r); chk("R8 refused while busy", r, 8'h00);
        rd1(16'h0003, r); chk("R8 chip erased", r, 8'hFF);

        // R10 deep power-down
        cmd(8'hB9);
        start(); xbyte(8'h05, d); xbyte(8'h00, d); stop();
        chk("R10 status refused", {7'd0, oe_seen}, 8'h00);
        start(); xbyte(8'h03, d); xbyte(8'h00, d); xbyte(8'h03, d); xbyte(8'h00, d); stop();
        chk("R10 read refused", {7'd0, oe_seen}, 8'h00);
        cmd(8'h06);
        start(); xbyte(8'hAB, d); xbyte(0, d); xbyte(0, d); xbyte(0, d);
        xbyte(0, r); xbyte(0, r2); stop();
        chk("R10 sig 0", r, SIGV); chk("R10 sig 1", r2, SIGV);
        rdsr(r); chk("R10 awake, latch untouched", r, 8'h00);

        // R7 status write
        cmd(8'h06); start(); xbyte(8'h01, d); xbyte(8'hA8, d); stop();
        rdsr(r); chk("R7 write", r, 8'hA8);
        start(); xbyte(8'h01, d); xbyte(8'h54, d); stop();
        rdsr(r); chk("R7 refused without latch", r, 8'hA8);
        cmd(8'h06); start(); xbyte(8'h01, d); xbyte(8'hFF, d); stop();
        rdsr(r); chk("R7 low bits", r, 8'hFC);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule